// File: doc/BRIEF.md
# HDLC Masked Station Address Filter

This block decides whether an incoming HDLC frame is meant for this station. A flag and framing stage upstream hands it a byte stream. A start strobe marks the first byte after the opening flag. An end strobe comes with a flag that tells whether the frame closed without error. The filter gathers the first two bytes into a 16-bit compare word. It checks that word against four programmable station addresses at the same time, under one shared 16-bit mask. It then reports, per slot and overall, whether the frame is accepted.

The decision appears one clock after the second byte and stays steady until the frame ends. A downstream buffer stage can therefore use it to keep or drop the frame's bytes. When a frame closes cleanly but no address slot matched, the filter emits a one-cycle pulse that a statistics counter can count. Clearing the upper half of the mask turns the filter into a single-byte recogniser. Clearing individual bits makes those bit positions wildcards.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After synchronous reset, `addr_done`, `addr_hit`, `slot_hit` and `miss_pulse` are all 0.
- R2: The first byte of a frame (the byte taken with `sof`) fills bits 7:0 of the compare word and the second byte fills bits 15:8; bytes 0x68 then 0xAA match slot value 0xAA68 under mask 0xFFFF, and bytes 0xAA then 0x68 do not.
- R3: A mask bit at 1 requires that compare-word bit to equal the slot bit, and a mask bit at 0 makes it a wildcard; mask 0x00FF therefore recognises on the first byte alone.
- R4: Slot k occupies `addr_slots[16k+15:16k]`, `slot_hit[k]` reports a match on slot k, several slots may match together, and `addr_hit` is 1 when any slot matches.
- R5: `addr_done`, `addr_hit` and `slot_hit` change in the cycle after the second byte is taken. They then hold, unaffected by further bytes or by changes of `addr_slots`/`addr_mask`, until the cycle after `eof`, when they return to 0.
- R6: A frame that ends after fewer than two bytes never raises `addr_done` or `addr_hit` and produces no `miss_pulse`.
- R7: `miss_pulse` is high for exactly the one cycle after an `eof` with `eof_ok`=1 that closes a decided frame with no slot matched.
- R8: No `miss_pulse` is produced when the closing `eof` has `eof_ok`=0 or when a slot matched.
- R9: A byte taken with `sof` always begins a new frame and drops any partial or decided state of the previous one; bytes without `sof` outside a frame are ignored.
- R10: In an `eof` cycle a byte without `sof` is ignored. With `sof` and `byte_valid` in the same cycle as `eof`, the old frame closes (including its `miss_pulse`) and the byte begins the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Marks the byte on `byte_data` as the first of a frame (taken only with `byte_valid`) |
| byte_valid | input | 1 | `byte_data` carries a received byte this cycle |
| byte_data | input | 8 | Received byte |
| eof | input | 1 | One-cycle end-of-frame strobe |
| eof_ok | input | 1 | Qualifies `eof`: frame closed without error |
| addr_slots | input | 64 | Four 16-bit station addresses, slot k in bits 16k+15:16k |
| addr_mask | input | 16 | Shared compare mask, 1 = compare, 0 = wildcard |
| addr_done | output | 1 | Address decision is valid for the current frame |
| addr_hit | output | 1 | Current frame is accepted (some slot matched) |
| slot_hit | output | 4 | Per-slot match result, bit k for slot k |
| miss_pulse | output | 1 | One-cycle pulse: clean frame ended unmatched |

## Verification
The hardest corners to reach are strobe collisions. Examples are an `eof` that shares its cycle with a new `sof` byte, or a stray byte without `sof` landing on the `eof` cycle or in idle time. Random framing alone almost never produces these. Directed sequences place those collisions cycle by cycle and check both the closing pulse of the old frame and the decision of the new one. Random frames then vary the gaps between bytes, the mask shape and the slot contents. Slots are often built from the frame's own address with bits flipped only under wildcard mask positions, so that single, multiple and no matches all occur.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  typedef enum logic {AF_IDLE = 1'b0, AF_BUSY = 1'b1} af_state_e;
  localparam int AF_BYTE_W = 8;
  localparam int AF_ADDR_W = 16;
  localparam int AF_SLOTS  = 4;
endpackage

// File: rtl/hdlc_af_capture.sv
module hdlc_af_capture
  import hdlc_af_pkg::*;
#(
  parameter int BW = AF_BYTE_W,
  parameter int AW = AF_ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sof,
  input  logic          byte_valid,
  input  logic [BW-1:0] byte_data,
  input  logic          eof,
  output logic [AW-1:0] word_nx,
  output logic          frame_start,
  output logic          last_addr
);
  localparam int NB = AW / BW;
  localparam int IW = $clog2(NB + 1);

  af_state_e     st_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] word_q;
  logic          take_next;

  assign frame_start = byte_valid && sof;
  assign take_next   = byte_valid && !sof && !eof && (st_q == AF_BUSY) && (idx_q < IW'(NB));
  assign last_addr   = (frame_start && (NB == 1)) || (take_next && (idx_q == IW'(NB - 1)));

  // next compare word: current byte dropped into its little-endian lane
  always_comb begin
    word_nx = frame_start ? '0 : word_q;
    for (int k = 0; k < NB; k++) begin
      if ((frame_start && k == 0) || (take_next && idx_q == IW'(k)))
        word_nx[k*BW +: BW] = byte_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= AF_IDLE;
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      word_q <= word_nx;
      if (frame_start) begin
        st_q  <= AF_BUSY;
        idx_q <= IW'(1);
      end else if (eof) begin
        st_q  <= AF_IDLE;
        idx_q <= '0;
      end else if (take_next) begin
        idx_q <= idx_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/hdlc_af_slot_cmp.sv
module hdlc_af_slot_cmp
  import hdlc_af_pkg::*;
#(
  parameter int AW    = AF_ADDR_W,
  parameter int NSLOT = AF_SLOTS
) (
  input  logic [AW-1:0]       word,
  input  logic [NSLOT*AW-1:0] slots,
  input  logic [AW-1:0]       mask,
  output logic [NSLOT-1:0]    hit
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign hit[g] = ~|((word ^ slots[g*AW +: AW]) & mask);
  end
endmodule

// File: rtl/hdlc_af_decide.sv
module hdlc_af_decide
  import hdlc_af_pkg::*;
#(
  parameter int NSLOT = AF_SLOTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             last_addr,
  input  logic [NSLOT-1:0] hit_vec,
  input  logic             eof,
  input  logic             eof_ok,
  output logic             addr_done,
  output logic             addr_hit,
  output logic [NSLOT-1:0] slot_hit,
  output logic             miss_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_done  <= 1'b0;
      addr_hit   <= 1'b0;
      slot_hit   <= '0;
      miss_pulse <= 1'b0;
    end else begin
      miss_pulse <= eof && eof_ok && addr_done && !addr_hit;
      if (eof || frame_start) begin
        addr_done <= 1'b0;
        addr_hit  <= 1'b0;
        slot_hit  <= '0;
      end
      if (last_addr) begin
        addr_done <= 1'b1;
        addr_hit  <= |hit_vec;
        slot_hit  <= hit_vec;
      end
    end
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int BW    = AF_BYTE_W,
  parameter int AW    = AF_ADDR_W,
  parameter int NSLOT = AF_SLOTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic             byte_valid,
  input  logic [BW-1:0]    byte_data,
  input  logic             eof,
  input  logic             eof_ok,
  input  logic [NSLOT*AW-1:0] addr_slots,
  input  logic [AW-1:0]    addr_mask,
  output logic             addr_done,
  output logic             addr_hit,
  output logic [NSLOT-1:0] slot_hit,
  output logic             miss_pulse
);
  logic [AW-1:0]    word_nx;
  logic             frame_start;
  logic             last_addr;
  logic [NSLOT-1:0] hit_vec;

  hdlc_af_capture #(.BW(BW), .AW(AW)) u_cap (
    .clk(clk), .rst(rst), .sof(sof), .byte_valid(byte_valid),
    .byte_data(byte_data), .eof(eof), .word_nx(word_nx),
    .frame_start(frame_start), .last_addr(last_addr)
  );

  hdlc_af_slot_cmp #(.AW(AW), .NSLOT(NSLOT)) u_cmp (
    .word(word_nx), .slots(addr_slots), .mask(addr_mask), .hit(hit_vec)
  );

  hdlc_af_decide #(.NSLOT(NSLOT)) u_dec (
    .clk(clk), .rst(rst), .frame_start(frame_start), .last_addr(last_addr),
    .hit_vec(hit_vec), .eof(eof), .eof_ok(eof_ok),
    .addr_done(addr_done), .addr_hit(addr_hit), .slot_hit(slot_hit),
    .miss_pulse(miss_pulse)
  );
endmodule

// File: rtl/hdlc_af_checker.sv
module hdlc_af_checker #(
  parameter int BW    = 8,
  parameter int AW    = 16,
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sof,
  input logic             byte_valid,
  input logic [BW-1:0]    byte_data,
  input logic             eof,
  input logic             eof_ok,
  input logic [NSLOT*AW-1:0] addr_slots,
  input logic [AW-1:0]    addr_mask,
  input logic             addr_done,
  input logic             addr_hit,
  input logic [NSLOT-1:0] slot_hit,
  input logic             miss_pulse
);
  assert_miss_single_R7: assert property (@(posedge clk) disable iff (rst)
    miss_pulse |=> !miss_pulse);

  assert_miss_cause_R7: assert property (@(posedge clk) disable iff (rst)
    miss_pulse |-> $past(eof && eof_ok && addr_done && !addr_hit));

  assert_hit_needs_done_R5: assert property (@(posedge clk) disable iff (rst)
    addr_hit |-> addr_done);

  assert_no_slots_undecided_R6: assert property (@(posedge clk) disable iff (rst)
    !addr_done |-> (slot_hit == '0));

  assert_decision_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (addr_done && !eof && !(sof && byte_valid)) |=> (addr_done && $stable(slot_hit)));

  assert_clear_on_eof_R5: assert property (@(posedge clk) disable iff (rst)
    (eof && !(sof && byte_valid)) |=> !addr_done);
endmodule

bind hdlc_addr_filter hdlc_af_checker #(.BW(BW), .AW(AW), .NSLOT(NSLOT)) u_chk (.*);

// File: tb/tb_hdlc_addr_filter.sv
`timescale 1ns/1ps
module tb_hdlc_addr_filter;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst, sof, byte_valid, eof, eof_ok;
  logic [7:0]  byte_data;
  logic [63:0] slots;
  logic [15:0] mask;
  logic        addr_done, addr_hit, miss_pulse;
  logic [3:0]  slot_hit;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  hdlc_addr_filter dut (
    .clk(clk), .rst(rst), .sof(sof), .byte_valid(byte_valid), .byte_data(byte_data),
    .eof(eof), .eof_ok(eof_ok), .addr_slots(slots), .addr_mask(mask),
    .addr_done(addr_done), .addr_hit(addr_hit), .slot_hit(slot_hit), .miss_pulse(miss_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [3:0] exp_hits(input logic [15:0] w, input logic [63:0] s,
                                          input logic [15:0] m);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = (((w ^ s[16*k +: 16]) & m) == 16'h0);
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    sof = 0; byte_valid = 0; eof = 0; eof_ok = 0; byte_data = 8'h00;
  endtask

  task automatic check_decided(input string req, input logic [3:0] e);
    chk(req, "addr_done", {31'd0, addr_done}, 32'd1);
    chk(req, "slot_hit", {28'd0, slot_hit}, {28'd0, e});
    chk(req, "addr_hit", {31'd0, addr_hit}, {31'd0, |e});
  endtask

  // one frame: b0 (with sof), gap, b1, more data bytes, eof
  task automatic send_frame(input logic [7:0] b0, input logic [7:0] b1, input int nbytes,
                            input bit ok, input int gap, input bit perturb, input string req);
    logic [3:0] e;
    bit         miss;
    e = 4'h0;
    if (nbytes >= 1) begin
      idle(); sof = 1; byte_valid = 1; byte_data = b0; step();
      idle();
      chk("R6", "addr_done after first byte", {31'd0, addr_done}, 32'd0);
      for (int g = 0; g < gap; g++) begin
        if (($urandom & 1) != 0) begin byte_valid = 0; end
        step();
        chk("R6", "addr_done in gap", {31'd0, addr_done}, 32'd0);
      end
    end
    if (nbytes >= 2) begin
      e = exp_hits({b1, b0}, slots, mask);
      byte_valid = 1; byte_data = b1; step(); idle();
      check_decided(req, e);
      for (int i = 2; i < nbytes; i++) begin
        byte_valid = 1; byte_data = 8'($urandom); step(); idle();
        if (perturb) begin slots = {$urandom, $urandom}; mask = 16'($urandom); end
        if (($urandom & 1) != 0) step();
        check_decided("R5", e);
      end
    end
    miss = ok && (nbytes >= 2) && (e == 4'h0);
    eof = 1; eof_ok = ok; step(); idle();
    chk("R5", "addr_done after eof", {31'd0, addr_done}, 32'd0);
    chk(miss ? "R7" : "R8", "miss_pulse", {31'd0, miss_pulse}, {31'd0, miss});
    step();
    chk("R7", "miss_pulse width", {31'd0, miss_pulse}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle(); slots = 64'h0; mask = 16'hFFFF; rst = 1;
    repeat (3) step();
    rst = 0; step();
    chk("R1", "addr_done", {31'd0, addr_done}, 32'd0);
    chk("R1", "addr_hit", {31'd0, addr_hit}, 32'd0);
    chk("R1", "slot_hit", {28'd0, slot_hit}, 32'd0);
    chk("R1", "miss_pulse", {31'd0, miss_pulse}, 32'd0);

    // R2 byte packing
    slots = {16'h1111, 16'hAA68, 16'h2222, 16'h3333}; mask = 16'hFFFF;
    send_frame(8'h68, 8'hAA, 4, 1, 0, 0, "R2");
    send_frame(8'hAA, 8'h68, 3, 1, 2, 0, "R2");
    // R3 mask: 8-bit recognition and single wildcard bit
    slots = {16'h0000, 16'h0000, 16'h0000, 16'h5A68}; mask = 16'h00FF;
    send_frame(8'h68, 8'h13, 3, 1, 1, 0, "R3");
    slots = {16'h0000, 16'h0000, 16'h0000, 16'hAA68}; mask = 16'hFFF7;
    send_frame(8'h60, 8'hAA, 2, 1, 0, 0, "R3");
    mask = 16'hFFFF;
    send_frame(8'h60, 8'hAA, 2, 1, 0, 0, "R3");
    // R4 multiple slots
    slots = {16'hBEEF, 16'h1234, 16'hBEEF, 16'h0000}; mask = 16'hFFFF;
    send_frame(8'hEF, 8'hBE, 3, 1, 0, 0, "R4");
    slots = {16'h0000, 16'h0000, 16'h0000, 16'h1234};
    send_frame(8'h34, 8'h12, 2, 1, 0, 0, "R4");
    // R5 config changes after decision do not move it
    slots = {16'hAA68, 16'h0000, 16'h0000, 16'h0000}; mask = 16'hFFFF;
    send_frame(8'h68, 8'hAA, 6, 1, 0, 1, "R5");
    // R6 short frames
    slots = 64'h0; mask = 16'h0000;
    send_frame(8'h00, 8'h00, 1, 1, 0, 0, "R6");
    send_frame(8'h00, 8'h00, 0, 1, 0, 0, "R6");
    // R8 error frame without match
    slots = 64'h0; mask = 16'hFFFF;
    send_frame(8'h55, 8'h66, 3, 0, 0, 0, "R8");

    // R9 sof restart mid-address and stray idle bytes
    slots = {16'h0000, 16'h0000, 16'h0000, 16'hAA68}; mask = 16'hFFFF;
    idle(); sof = 1; byte_valid = 1; byte_data = 8'h11; step();
    sof = 1; byte_valid = 1; byte_data = 8'h68; step();
    idle(); byte_valid = 1; byte_data = 8'hAA; step(); idle();
    check_decided("R9", 4'b0001);
    sof = 1; byte_valid = 1; byte_data = 8'h00; step(); idle();
    chk("R9", "restart clears decision", {31'd0, addr_done}, 32'd0);
    eof = 1; eof_ok = 1; step(); idle(); step();
    byte_valid = 1; byte_data = 8'h68; step();
    byte_data = 8'hAA; step(); idle();
    chk("R9", "idle bytes ignored", {31'd0, addr_done}, 32'd0);

    // R10 byte in eof cycle ignored
    sof = 1; byte_valid = 1; byte_data = 8'h68; step(); idle();
    eof = 1; eof_ok = 1; byte_valid = 1; byte_data = 8'hAA; step(); idle();
    chk("R10", "eof byte ignored", {31'd0, addr_done}, 32'd0);
    byte_valid = 1; byte_data = 8'hAA; step(); idle();
    chk("R10", "no frame after eof", {31'd0, addr_done}, 32'd0);
    chk("R10", "short frame no miss", {31'd0, miss_pulse}, 32'd0);

    // R10 eof and sof in the same cycle
    sof = 1; byte_valid = 1; byte_data = 8'h01; step(); idle();
    byte_valid = 1; byte_data = 8'h02; step(); idle();
    check_decided("R10", 4'b0000);
    eof = 1; eof_ok = 1; sof = 1; byte_valid = 1; byte_data = 8'h68; step(); idle();
    chk("R10", "old frame miss", {31'd0, miss_pulse}, 32'd1);
    chk("R10", "old decision cleared", {31'd0, addr_done}, 32'd0);
    byte_valid = 1; byte_data = 8'hAA; step(); idle();
    check_decided("R10", 4'b0001);
    chk("R10", "miss one cycle", {31'd0, miss_pulse}, 32'd0);
    eof = 1; eof_ok = 1; step(); idle(); step();

    // random frames
    for (int f = 0; f < 400; f++) begin
      logic [7:0]  b0, b1;
      logic [15:0] w;
      b0 = 8'($urandom); b1 = 8'($urandom); w = {b1, b0};
      case ($urandom % 3)
        0: mask = 16'hFFFF;
        1: mask = 16'h00FF;
        default: mask = 16'($urandom);
      endcase
      for (int k = 0; k < 4; k++) begin
        if (($urandom % 3) == 0) slots[16*k +: 16] = 16'($urandom);
        else slots[16*k +: 16] = w ^ (16'($urandom) & ~mask & 16'(($urandom & 1) ? 16'hFFFF : 16'h0)) ^
                                 ((($urandom % 4) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0);
      end
      send_frame(b0, b1, int'($urandom % 7), bit'($urandom & 1), int'($urandom % 3), 0, "R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule